// File: doc/BRIEF.md
# March LR Memory Test Sequencer

This block produces the stimulus and the expected responses for a self-test of a small synchronous single-port RAM of 32 words by 4 bits. After a start pulse it runs a fixed program of march elements. Each element visits every address in a set direction and applies a short list of reads and writes at each address. The write address, read address, write enable, read enable and write data go straight to the RAM. For every read, the block also presents the data a fault-free RAM must return, together with a one-cycle valid strobe that lines up with the RAM's registered read data. A separate comparator outside this block uses that data.

The program has three passes. The first pass is the six-element march on a solid background: 0000, with 1111 as its inverse. Each later pass adds three elements built on a new background, 0101 in the second pass and 0011 in the third. These elements read the previous background and replace it with the new pattern and its inverse. This exercises the bits within a word against each other, which a solid-only march does not do.

The controller is a three-state machine. **IDLE** waits. The transition *launch* (IDLE to RUN) happens on start. **RUN** issues one memory operation per cycle and stays in RUN (*advance*) until the operation list is used up. The transition *finish* (RUN to DONE) follows the last operation. **DONE** lasts exactly one cycle, and the transition *retire* (DONE to IDLE) is unconditional.

Top module: `march_lr_bist`

## Requirements
- R1: While reset is low, and in IDLE, the outputs busy, done, we, oe, exp_valid, wr_addr, rd_addr and wr_data are all zero.
- R2: A start pulse sampled high in IDLE makes busy high from the next cycle. The first operation is a write of 0000 to address 0.
- R3: A run is exactly 1024 consecutive busy cycles, one operation per cycle, in this element order (B = background, N = its inverse, P = the previous background, w = write, r = read). Pass 0 uses B=0000: up(wB); down(rB,wN); up(rN,wB,rB,rB,wN); up(rN,wB); up(rB,wN,rN,rN,wB); up(rB). This is 16 operations per word. Passes 1 and 2 each add up(rP,wB,wN,rN); up(rN,wB,rB); up(rB). This is 8 operations per word per pass.
- R4: Within an element, all of that element's operations are applied to one address before the address moves. The descending element goes from address 31 down to 0, and every other element goes from 0 up to 31.
- R5: Backgrounds are 0000 in pass 0, 0101 in pass 1 and 0011 in pass 2, written as bit 3 to bit 0. The written data equals the selected background or its inverse as listed in R3.
- R6: During RUN exactly one of we (write) and oe (read) is high, and wr_addr equals rd_addr.
- R7: exp_valid is high for exactly one cycle, the cycle after each read operation. In that cycle exp_data holds the value a fault-free RAM returns for that read, which is the value last written to that address.
- R8: done is high for one cycle, in the same cycle as the final exp_valid, with busy low. The next cycle is IDLE.
- R9: start is ignored outside IDLE, including in the DONE cycle. A run is neither restarted nor lengthened by it.
- R10: A start after a completed run reproduces the identical operation sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a test run (honoured in IDLE only) |
| busy | output | 1 | High while operations are issued |
| done | output | 1 | One-cycle end-of-run pulse |
| we | output | 1 | RAM write enable |
| oe | output | 1 | RAM read enable |
| wr_addr | output | 5 | RAM write address |
| rd_addr | output | 5 | RAM read address |
| wr_data | output | 4 | RAM write data |
| exp_valid | output | 1 | Expected read data is valid this cycle |
| exp_data | output | 4 | Data the RAM read must return |

## Verification
A wrong element index, operation index or pass counter shows up immediately at the ports. The very next cycle carries a we/oe choice, an address or a write value that differs from the reference list, so the per-cycle comparison of the operation stream flags it within one cycle. A wrong background or data selection on a read shows up one cycle later: exp_data disagrees both with the reference list and with a behavioural RAM driven by the block's own writes. A counter that ends an element early or late changes the number of busy cycles and moves the done pulse, and this is caught at the end of the run.

// File: rtl/mlr_pkg.sv
package mlr_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_RUN,
        ST_DONE
    } mlr_state_e;

    // data source for an operation
    typedef enum logic [1:0] {
        DS_BG,
        DS_INV,
        DS_PREV
    } dsel_e;

    typedef struct packed {
        logic  wr;
        dsel_e sel;
    } mop_t;

    localparam int ELEM_W = 4;
    localparam int OPI_W  = 3;

    localparam logic [ELEM_W-1:0] EL_BASE_LAST   = 4'd5;
    localparam logic [ELEM_W-1:0] EL_EXTRA_FIRST = 4'd6;
    localparam logic [ELEM_W-1:0] EL_EXTRA_LAST  = 4'd8;

    function automatic logic elem_down(input logic [ELEM_W-1:0] e);
        return (e == 4'd1);
    endfunction

    function automatic logic [OPI_W-1:0] elem_len(input logic [ELEM_W-1:0] e);
        logic [OPI_W-1:0] n;
        case (e)
            4'd1, 4'd3: n = 3'd2;
            4'd2, 4'd4: n = 3'd5;
            4'd6:       n = 3'd4;
            4'd7:       n = 3'd3;
            default:    n = 3'd1;
        endcase
        return n;
    endfunction

    function automatic mop_t mk(input logic w, input dsel_e s);
        mop_t m;
        m.wr  = w;
        m.sel = s;
        return m;
    endfunction

    function automatic mop_t elem_op(input logic [ELEM_W-1:0] e,
                                     input logic [OPI_W-1:0]  i);
        mop_t m;
        m = mk(1'b0, DS_BG);
        case (e)
            4'd0: m = mk(1'b1, DS_BG);
            4'd1: m = (i == 3'd0) ? mk(1'b0, DS_BG) : mk(1'b1, DS_INV);
            4'd2: case (i)
                      3'd0:    m = mk(1'b0, DS_INV);
                      3'd1:    m = mk(1'b1, DS_BG);
                      3'd4:    m = mk(1'b1, DS_INV);
                      default: m = mk(1'b0, DS_BG);
                  endcase
            4'd3: m = (i == 3'd0) ? mk(1'b0, DS_INV) : mk(1'b1, DS_BG);
            4'd4: case (i)
                      3'd0:    m = mk(1'b0, DS_BG);
                      3'd1:    m = mk(1'b1, DS_INV);
                      3'd4:    m = mk(1'b1, DS_BG);
                      default: m = mk(1'b0, DS_INV);
                  endcase
            4'd6: case (i)
                      3'd0:    m = mk(1'b0, DS_PREV);
                      3'd1:    m = mk(1'b1, DS_BG);
                      3'd2:    m = mk(1'b1, DS_INV);
                      default: m = mk(1'b0, DS_INV);
                  endcase
            4'd7: case (i)
                      3'd0:    m = mk(1'b0, DS_INV);
                      3'd1:    m = mk(1'b1, DS_BG);
                      default: m = mk(1'b0, DS_BG);
                  endcase
            default: m = mk(1'b0, DS_BG);
        endcase
        return m;
    endfunction

endpackage

// File: rtl/mlr_bg_gen.sv
module mlr_bg_gen #(
    parameter int DATA_W = 4,
    parameter int PASS_W = 2
) (
    input  logic [PASS_W-1:0] pass_idx,
    output logic [DATA_W-1:0] bg,
    output logic [DATA_W-1:0] prev_bg
);
    localparam int KW = (DATA_W > 1) ? $clog2(DATA_W) : 1;

    // pass 0 is solid zero; pass p sets bit k when bit p-1 of k is clear
    function automatic logic [DATA_W-1:0] pattern(input logic [PASS_W-1:0] p);
        logic [DATA_W-1:0] v;
        logic [KW-1:0]     kv;
        v = '0;
        for (int k = 0; k < DATA_W; k++) begin
            kv = KW'(k);
            if (p != '0) begin
                v[k] = ~kv[p - 1'b1];
            end
        end
        return v;
    endfunction

    always_comb begin
        bg      = pattern(pass_idx);
        prev_bg = (pass_idx == '0) ? '0 : pattern(pass_idx - 1'b1);
    end

endmodule

// File: rtl/mlr_addr_ctr.sv
module mlr_addr_ctr #(
    parameter int ADDR_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              load_down,
    input  logic              step,
    input  logic              down,
    output logic [ADDR_W-1:0] addr,
    output logic              at_end
);
    localparam logic [ADDR_W-1:0] TOP_ADDR = '1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr <= '0;
        end else if (load) begin
            addr <= load_down ? TOP_ADDR : '0;
        end else if (step) begin
            addr <= down ? addr - 1'b1 : addr + 1'b1;
        end
    end

    assign at_end = down ? (addr == '0) : (addr == TOP_ADDR);

endmodule

// File: rtl/mlr_op_dec.sv
module mlr_op_dec
    import mlr_pkg::*;
(
    input  logic [ELEM_W-1:0] elem,
    input  logic [OPI_W-1:0]  opi,
    output mop_t              op,
    output logic              last_op,
    output logic              down
);
    always_comb begin
        op      = elem_op(elem, opi);
        last_op = (opi == elem_len(elem) - 1'b1);
        down    = elem_down(elem);
    end

endmodule

// File: rtl/march_lr_bist.sv
module march_lr_bist
    import mlr_pkg::*;
#(
    parameter int ADDR_W = 5,
    parameter int DATA_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    output logic              busy,
    output logic              done,
    output logic              we,
    output logic              oe,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] wr_data,
    output logic              exp_valid,
    output logic [DATA_W-1:0] exp_data
);
    localparam int NUM_BG = ((DATA_W > 1) ? $clog2(DATA_W) : 0) + 1;
    localparam int PASS_W = (NUM_BG > 1) ? $clog2(NUM_BG) : 1;
    localparam logic [PASS_W-1:0] PASS_LAST = PASS_W'(NUM_BG - 1);

    mlr_state_e        state_q, state_d;
    logic [PASS_W-1:0] pass_q, pass_d;
    logic [ELEM_W-1:0] elem_q, elem_d;
    logic [OPI_W-1:0]  opi_q, opi_d;

    logic              ctr_load, ctr_load_down, ctr_step;
    logic [ADDR_W-1:0] addr;
    logic              at_end;
    mop_t              op;
    logic              last_op, op_down;
    logic [DATA_W-1:0] bg, prev_bg, op_data;
    logic [ELEM_W-1:0] pass_last_elem;

    mlr_op_dec u_dec (
        .elem    (elem_q),
        .opi     (opi_q),
        .op      (op),
        .last_op (last_op),
        .down    (op_down)
    );

    mlr_addr_ctr #(.ADDR_W(ADDR_W)) u_addr (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (ctr_load),
        .load_down (ctr_load_down),
        .step      (ctr_step),
        .down      (op_down),
        .addr      (addr),
        .at_end    (at_end)
    );

    mlr_bg_gen #(.DATA_W(DATA_W), .PASS_W(PASS_W)) u_bg (
        .pass_idx (pass_q),
        .bg       (bg),
        .prev_bg  (prev_bg)
    );

    always_comb begin
        unique case (op.sel)
            DS_INV:  op_data = ~bg;
            DS_PREV: op_data = prev_bg;
            default: op_data = bg;
        endcase
    end

    assign pass_last_elem = (pass_q == '0) ? EL_BASE_LAST : EL_EXTRA_LAST;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            pass_q  <= '0;
            elem_q  <= '0;
            opi_q   <= '0;
        end else begin
            state_q <= state_d;
            pass_q  <= pass_d;
            elem_q  <= elem_d;
            opi_q   <= opi_d;
        end
    end

    // next-state and sequencing
    always_comb begin
        state_d  = state_q;
        pass_d   = pass_q;
        elem_d   = elem_q;
        opi_d    = opi_q;
        ctr_load = 1'b0;
        ctr_step = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (start) begin
                    state_d  = ST_RUN;
                    pass_d   = '0;
                    elem_d   = '0;
                    opi_d    = '0;
                    ctr_load = 1'b1;
                end
            end
            ST_RUN: begin
                if (!last_op) begin
                    opi_d = opi_q + 1'b1;
                end else begin
                    opi_d = '0;
                    if (!at_end) begin
                        ctr_step = 1'b1;
                    end else if (elem_q != pass_last_elem) begin
                        elem_d   = elem_q + 1'b1;
                        ctr_load = 1'b1;
                    end else if (pass_q != PASS_LAST) begin
                        pass_d   = pass_q + 1'b1;
                        elem_d   = EL_EXTRA_FIRST;
                        ctr_load = 1'b1;
                    end else begin
                        state_d = ST_DONE;
                    end
                end
            end
            ST_DONE: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
        ctr_load_down = elem_down(elem_d);
    end

    // outputs
    always_comb begin
        busy    = (state_q == ST_RUN);
        done    = (state_q == ST_DONE);
        we      = busy & op.wr;
        oe      = busy & ~op.wr;
        wr_addr = busy ? addr : '0;
        rd_addr = busy ? addr : '0;
        wr_data = we ? op_data : '0;
    end

    // expected-data stage aligned to registered RAM read
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            exp_valid <= 1'b0;
            exp_data  <= '0;
        end else begin
            exp_valid <= oe;
            exp_data  <= oe ? op_data : '0;
        end
    end

endmodule

// File: rtl/mlr_checker.sv
module mlr_checker #(
    parameter int ADDR_W = 5,
    parameter int DATA_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic              busy,
    input logic              done,
    input logic              we,
    input logic              oe,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [ADDR_W-1:0] rd_addr,
    input logic [DATA_W-1:0] wr_data,
    input logic              exp_valid,
    input logic [DATA_W-1:0] exp_data
);
    p_quiet_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!we && !oe && wr_data == '0));

    p_one_op_r6: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> ($countones({we, oe}) == 1 && wr_addr == rd_addr));

    p_read_strobe_r7: assert property (@(posedge clk) disable iff (!rst_n)
        oe |=> exp_valid);

    p_no_stray_strobe_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !oe |=> !exp_valid);

    p_done_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done && !busy);

    p_done_after_run_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && $past(busy)));

    p_run_holds_r9: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> (busy || done));

    p_start_in_run_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start) |=> (busy || done));

endmodule

bind march_lr_bist mlr_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (.*);

// File: tb/march_lr_bist_test.sv
`timescale 1ns/1ps
module march_lr_bist_test;

    localparam int N_OPS = 1024;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic       busy, done, we, oe, exp_valid;
    logic [4:0] wr_addr, rd_addr;
    logic [3:0] wr_data, exp_data;

    int n_chk  = 0;
    int n_fail = 0;

    logic       e_wr [N_OPS];
    logic [4:0] e_ad [N_OPS];
    logic [3:0] e_dt [N_OPS];
    int         n_fill = 0;

    logic [3:0] mem [32];
    logic [3:0] rq;

    always #2.5 clk = ~clk;

    march_lr_bist uut (
        .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
        .we(we), .oe(oe), .wr_addr(wr_addr), .rd_addr(rd_addr),
        .wr_data(wr_data), .exp_valid(exp_valid), .exp_data(exp_data)
    );

    // behavioural fault-free RAM with registered read
    always_ff @(posedge clk) begin
        if (we) mem[wr_addr] <= wr_data;
        if (oe) rq <= mem[rd_addr];
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // one element: wm bit i marks op i as write, dv nibble i is its data
    task automatic add_elem(input bit dn, input int n, input logic [4:0] wm,
                            input logic [19:0] dv);
        for (int s = 0; s < 32; s++) begin
            int a;
            a = dn ? 31 - s : s;
            for (int i = 0; i < n; i++) begin
                e_wr[n_fill] = wm[i];
                e_ad[n_fill] = 5'(a);
                e_dt[n_fill] = dv[i*4 +: 4];
                n_fill++;
            end
        end
    endtask

    function automatic logic [3:0] bench_bg(input int j);
        case (j)
            0:       return 4'b0000;
            1:       return 4'b0101;
            default: return 4'b0011;
        endcase
    endfunction

    task automatic build_ref();
        logic [3:0] b, n, p;
        b = bench_bg(0);
        n = ~b;
        add_elem(1'b0, 1, 5'b00001, {16'h0, b});
        add_elem(1'b1, 2, 5'b00010, {12'h0, n, b});
        add_elem(1'b0, 5, 5'b10010, {n, b, b, b, n});
        add_elem(1'b0, 2, 5'b00010, {12'h0, b, n});
        add_elem(1'b0, 5, 5'b10010, {b, n, n, n, b});
        add_elem(1'b0, 1, 5'b00000, {16'h0, b});
        for (int j = 1; j < 3; j++) begin
            p = bench_bg(j - 1);
            b = bench_bg(j);
            n = ~b;
            add_elem(1'b0, 4, 5'b00110, {4'h0, n, n, b, p});
            add_elem(1'b0, 3, 5'b00010, {8'h0, b, b, n});
            add_elem(1'b0, 1, 5'b00000, {16'h0, b});
        end
    endtask

    task automatic check_idle(input string req);
        chk(!busy && !done && !we && !oe && !exp_valid, req, "idle flags",
            {27'h0, busy, done, we, oe, exp_valid}, 32'h0);
        chk(wr_addr == 5'd0 && rd_addr == 5'd0 && wr_data == 4'd0, req,
            "idle address/data", {18'h0, wr_addr, rd_addr, wr_data}, 32'h0);
    endtask

    // mode 0: clean start; 1: random stray starts; 2: start held every cycle
    task automatic run_once(input int mode, input bit is_repeat);
        int errs;
        int busy_cnt;
        bit ev;
        errs = 0;
        busy_cnt = 0;
        repeat ($urandom_range(1, 6)) @(negedge clk);
        check_idle("R1");
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int k = 0; k <= N_OPS; k++) begin
            if (k < N_OPS) begin
                if (busy) busy_cnt++;
                if (k == 0) begin
                    chk(busy, "R2", "busy after start", busy, 1);
                    chk(we && wr_addr == 5'd0 && wr_data == 4'd0, "R2", "first op",
                        {we, wr_addr, wr_data}, {1'b1, 5'd0, 4'd0});
                end
                chk(we == e_wr[k] && oe == !e_wr[k], "R3", $sformatf("op kind %0d", k),
                    {we, oe}, {e_wr[k], !e_wr[k]});
                chk(wr_addr == e_ad[k], "R4", $sformatf("address %0d", k),
                    wr_addr, e_ad[k]);
                chk(rd_addr == wr_addr && (we ^ oe), "R6", $sformatf("port agreement %0d", k),
                    rd_addr, wr_addr);
                if (e_wr[k]) begin
                    chk(wr_data == e_dt[k], "R5", $sformatf("write data %0d", k),
                        wr_data, e_dt[k]);
                    if (wr_data != e_dt[k]) errs++;
                end
                if (we != e_wr[k] || wr_addr != e_ad[k]) errs++;
                chk(!done, "R8", "done early", done, 0);
            end else begin
                chk(!busy && done, "R8", "done cycle", {busy, done}, 2'b01);
            end
            ev = (k > 0) && !e_wr[k-1];
            chk(exp_valid == ev, "R7", $sformatf("strobe %0d", k), exp_valid, ev);
            if (ev) begin
                chk(exp_data == e_dt[k-1], "R7", $sformatf("expected data %0d", k),
                    exp_data, e_dt[k-1]);
                chk(exp_data == rq, "R7", $sformatf("RAM agreement %0d", k),
                    exp_data, rq);
            end
            if (mode == 2) start = 1'b1;
            else if (mode == 1) start = ($urandom % 8) == 0;
            else start = 1'b0;
            @(negedge clk);
        end
        start = 1'b0;
        chk(busy_cnt == N_OPS, "R9", "busy cycle count", busy_cnt, N_OPS);
        check_idle("R8");
        @(negedge clk);
        check_idle("R9");
        if (is_repeat) chk(errs == 0, "R10", "repeat run mismatches", errs, 0);
    endtask

    initial begin
        void'($urandom(32'd4242));
        build_ref();
        start = 1'b1;
        repeat (3) @(negedge clk);
        check_idle("R1");
        start = 1'b0;
        rst_n = 1'b1;
        run_once(0, 1'b0);
        run_once(1, 1'b1);
        run_once(2, 1'b1);
        // reset in mid-run returns outputs to idle
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (100) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check_idle("R1");
        rst_n = 1'b1;
        run_once(1, 1'b1);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL R3 watchdog: actual %0d expected %0d", 150000, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule